// File: doc/BRIEF.md
# Four-Port Address-Routed Packet Router

The router takes a byte stream on one ingress port and delivers each packet, whole and in its original byte order, to one of four egress ports. A packet is framed by a level strobe: the strobe is high for exactly the cycles that carry the packet's bytes, one byte per clock. Between packets the strobe stays low for at least three cycles. The first byte of each packet is its destination. The router compares this byte against a four-entry address table that is written at runtime. Entry i holds the address of egress port i.

Each egress port has its own 512-byte FIFO, which holds at least one packet of the maximum size (259 bytes). A port raises its ready output only after a complete packet has been stored. A consumer then pulls bytes with a read strobe, and each byte arrives on the data output one clock after the strobe is sampled. The router discards a packet in two cases: its destination matches no table entry, or the target FIFO lacks room for a maximum-size packet when the first byte arrives. The length byte and the check byte are carried through without being interpreted.

Top module: `addr_router`

## Requirements
- R1: An active-high asynchronous reset clears all four table entries to 0x00, empties every FIFO, drives every ready low and every egress data output to 0x00.
- R2: At a rising edge where cfg_en and cfg_wr are both high, entry cfg_idx takes cfg_data. When cfg_en is high and cfg_wr is low, the table is unchanged.
- R3: A packet begins at the first cycle in which in_valid is high after a low cycle, and that cycle carries the destination byte. Every following high cycle carries one more byte, and the first low cycle ends the packet. Packets separated by exactly three idle cycles are each routed on their own.
- R4: A packet whose destination byte equals entry i is stored, all bytes in order, in FIFO i alone. No other port ever shows any of its bytes.
- R5: A port's ready goes high in the cycle after the clock edge that samples in_valid low following the packet's last byte, and not earlier.
- R6: A read sampled high while ready is high pops one byte, and that byte appears on the port's data output after the same edge. A read sampled while ready is low is ignored, and the data output holds its value.
- R7: Ready stays high while any byte of a completely stored packet is unread. It falls only after a read consumes the last such byte, even while another packet for that port is still arriving.
- R8: A packet whose destination matches no entry is discarded, and no port's ready or data changes because of it.
- R9: If the target FIFO has fewer than 259 free byte slots when the destination byte arrives, the whole packet is discarded. Later packets are accepted once reads have freed enough room.
- R10: The length byte and the check byte are forwarded unchanged and do not affect framing or routing. A packet's extent comes only from the strobe, even when the length byte disagrees or the check byte is wrong.
- R11: A table write takes effect for packets whose destination byte arrives after the write edge. A packet already in flight stays on the port chosen at its first byte.
- R12: When several entries hold the destination value, the lowest-numbered port receives the packet. So after reset, a packet to 0x00 lands on port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| cfg_en | input | 1 | Table access enable |
| cfg_wr | input | 1 | Table write select (1 = write) |
| cfg_idx | input | 2 | Table entry index |
| cfg_data | input | 8 | Address value to store |
| in_valid | input | 1 | Ingress strobe, high during a packet |
| in_data | input | 8 | Ingress byte |
| out_data | output | 32 | Egress bytes, port i in bits 8i+7..8i |
| out_ready | output | 4 | Port i holds at least one unread byte of a complete packet |
| out_read | input | 4 | Port i pops one byte |

## Verification
A corrupted table entry or wrong match priority shows up within one packet: bytes appear on the wrong port, or a ready rises where the model expects none. A wrong write, commit or read pointer shows up at the egress as a wrong byte, a ready that rises early or late, or a ready that falls early. The model compares every port every cycle, so the mismatch is reported in the first cycle it reaches the ports. Room accounting is exercised by stacking two maximum-size packets on one port, and the in-flight table rewrite exposes any re-evaluation of the route in the middle of a packet.

// File: rtl/arouter_pkg.sv
package arouter_pkg;
  localparam int unsigned BYTE_W        = 8;
  localparam int unsigned PORTS         = 4;
  localparam int unsigned FIFO_DEPTH    = 512;
  localparam int unsigned MAX_PKT_BYTES = 259;
endpackage

// File: rtl/arouter_cfg.sv
// Runtime-written destination table, one entry per egress port.
module arouter_cfg #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [$clog2(N)-1:0] wr_idx,
  input  logic [W-1:0]         wr_val,
  output logic [N*W-1:0]       entries
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      entries <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < N; i++) begin
        if (wr_idx == i[$clog2(N)-1:0]) entries[i*W +: W] <= wr_val;
      end
    end
  end
endmodule

// File: rtl/arouter_ingress.sv
// Frames packets from the strobe, picks the port on the first byte,
// and steers writes/commits to that port's FIFO.
module arouter_ingress #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [W-1:0]   in_data,
  input  logic [N*W-1:0] entries,
  input  logic [N-1:0]   room,
  output logic [N-1:0]   wr_en,
  output logic [W-1:0]   wr_data,
  output logic [N-1:0]   commit
);
  logic           prev_valid;
  logic [N-1:0]   cur_sel;
  logic           cur_ok;
  logic [N-1:0]   hit;
  logic [N-1:0]   pick;
  logic [N-1:0]   route;
  logic           start;
  logic           ok_now;

  // address compare, one comparator per port
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = (entries[g*W +: W] == in_data);
  end

  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
    start   = in_valid & ~prev_valid;
    ok_now  = |(pick & room);
    if (start) route = ok_now ? pick : '0;
    else       route = cur_ok ? cur_sel : '0;
    wr_en   = in_valid ? route : '0;
    wr_data = in_data;
    commit  = (~in_valid & prev_valid & cur_ok) ? cur_sel : '0;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      prev_valid <= 1'b0;
      cur_sel    <= '0;
      cur_ok     <= 1'b0;
    end else begin
      prev_valid <= in_valid;
      if (start) begin
        cur_sel <= pick;
        cur_ok  <= ok_now;
      end
    end
  end
endmodule

// File: rtl/arouter_fifo.sv
// Per-port byte FIFO with a commit pointer: only whole packets are visible.
module arouter_fifo #(
  parameter int unsigned W       = 8,
  parameter int unsigned DEPTH   = 512,
  parameter int unsigned MAX_PKT = 259
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         commit,
  input  logic         rd_req,
  output logic [W-1:0] rd_data,
  output logic         ready,
  output logic         room
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_LVL   = (AW+1)'(DEPTH);
  localparam logic [AW:0] ROOM_LIMIT = (AW+1)'(DEPTH - MAX_PKT);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr, cm_ptr, rd_ptr, used;
  logic         push, pop;

  always_comb begin
    used  = wr_ptr - rd_ptr;
    push  = wr_en & (used != FULL_LVL);
    ready = (cm_ptr != rd_ptr);
    pop   = rd_req & ready;
    room  = (used <= ROOM_LIMIT);
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wr_ptr  <= '0;
      cm_ptr  <= '0;
      rd_ptr  <= '0;
      rd_data <= '0;
    end else begin
      if (push)   wr_ptr <= wr_ptr + 1'b1;
      if (commit) cm_ptr <= wr_ptr;
      if (pop) begin
        rd_data <= mem[rd_ptr[AW-1:0]];
        rd_ptr  <= rd_ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/addr_router.sv
module addr_router
  import arouter_pkg::*;
#(
  parameter int unsigned W       = BYTE_W,
  parameter int unsigned N       = PORTS,
  parameter int unsigned DEPTH   = FIFO_DEPTH,
  parameter int unsigned MAX_PKT = MAX_PKT_BYTES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_en,
  input  logic                 cfg_wr,
  input  logic [$clog2(N)-1:0] cfg_idx,
  input  logic [W-1:0]         cfg_data,
  input  logic                 in_valid,
  input  logic [W-1:0]         in_data,
  output logic [N*W-1:0]       out_data,
  output logic [N-1:0]         out_ready,
  input  logic [N-1:0]         out_read
);
  logic [N*W-1:0] entries;
  logic [N-1:0]   fifo_wr;
  logic [N-1:0]   fifo_commit;
  logic [N-1:0]   fifo_room;
  logic [W-1:0]   fifo_byte;

  arouter_cfg #(.W(W), .N(N)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_en & cfg_wr),
    .wr_idx  (cfg_idx),
    .wr_val  (cfg_data),
    .entries (entries)
  );

  arouter_ingress #(.W(W), .N(N)) u_ing (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .entries  (entries),
    .room     (fifo_room),
    .wr_en    (fifo_wr),
    .wr_data  (fifo_byte),
    .commit   (fifo_commit)
  );

  for (genvar p = 0; p < N; p++) begin : g_port
    arouter_fifo #(.W(W), .DEPTH(DEPTH), .MAX_PKT(MAX_PKT)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (fifo_wr[p]),
      .wr_data (fifo_byte),
      .commit  (fifo_commit[p]),
      .rd_req  (out_read[p]),
      .rd_data (out_data[p*W +: W]),
      .ready   (out_ready[p]),
      .room    (fifo_room[p])
    );
  end
endmodule

// File: rtl/arouter_chk.sv
module arouter_chk #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [N-1:0]   ready,
  input logic [N-1:0]   read,
  input logic [N*W-1:0] out_data,
  input logic [N-1:0]   fifo_wr
);
  // R1: reset leaves every port empty with zero data
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (ready == '0 && out_data == '0));

  // R4: a byte is written into at most one port
  a_r4_single_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fifo_wr));

  for (genvar i = 0; i < N; i++) begin : g_p
    // R6: read while not ready leaves the data output alone
    a_r6_idle_read_holds: assert property (@(posedge clk) disable iff (rst)
      !ready[i] |=> $stable(out_data[i*W +: W]));
    // R7: ready only falls as a result of a read
    a_r7_fall_by_read: assert property (@(posedge clk) disable iff (rst)
      $fell(ready[i]) |-> $past(read[i]));
    // R5: ready only rises right after a frame end
    a_r5_rise_after_end: assert property (@(posedge clk) disable iff (rst)
      $rose(ready[i]) |-> (!$past(in_valid) && $past(in_valid, 2)));
  end
endmodule

bind addr_router arouter_chk #(.W(W), .N(N)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .ready    (out_ready),
  .read     (out_read),
  .out_data (out_data),
  .fifo_wr  (fifo_wr)
);

// File: tb/sim_addr_router.sv
module sim_addr_router;
  localparam int W = 8;
  localparam int N = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst = 1'b1;
  logic           cfg_en = 1'b0, cfg_wr = 1'b0;
  logic [1:0]     cfg_idx = '0;
  logic [W-1:0]   cfg_data = '0;
  logic           in_valid = 1'b0;
  logic [W-1:0]   in_data = '0;
  logic [N-1:0]   rd = '0;
  logic [N*W-1:0] odata;
  logic [N-1:0]   rdy;

  addr_router u0 (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .in_valid(in_valid), .in_data(in_data),
    .out_data(odata), .out_ready(rdy), .out_read(rd)
  );

  int    checks = 0;
  int    errors = 0;
  string phase  = "R1";

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_tab [N];
  logic [7:0] m_store [N][$];
  int         m_avail [N];
  logic [7:0] m_dout [N];
  bit         m_prev, m_ok, m_hit;
  int         m_port, m_tgt;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_tab[i] = 8'h00; m_store[i].delete(); m_avail[i] = 0; m_dout[i] = 8'h00;
      end
      m_prev = 0; m_ok = 0; m_port = 0;
    end else begin
      if (in_valid && !m_prev) begin
        m_hit = 0; m_tgt = 0;
        for (int i = N - 1; i >= 0; i--)
          if (m_tab[i] == in_data) begin m_hit = 1; m_tgt = i; end
        m_port = m_tgt;
        m_ok   = m_hit && ((512 - m_store[m_tgt].size()) >= 259);
      end
      for (int i = 0; i < N; i++)
        if (rd[i] && m_avail[i] > 0) begin
          m_dout[i] = m_store[i].pop_front();
          m_avail[i]--;
        end
      if (in_valid && m_ok && m_store[m_port].size() < 512)
        m_store[m_port].push_back(in_data);
      if (!in_valid && m_prev && m_ok)
        m_avail[m_port] = m_store[m_port].size();
      m_prev = in_valid;
      if (cfg_en && cfg_wr) m_tab[cfg_idx] = cfg_data;
    end
  end

  // compare every port on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < N; i++) begin
        check(rdy[i] === (m_avail[i] > 0), $sformatf("ready port %0d", i),
              int'(rdy[i]), int'(m_avail[i] > 0));
        check(odata[i*W +: W] === m_dout[i], $sformatf("data port %0d", i),
              int'(odata[i*W +: W]), int'(m_dout[i]));
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic cfg_write(input int idx, input logic [7:0] val, input bit wr);
    cfg_en = 1'b1; cfg_wr = wr; cfg_idx = 2'(idx); cfg_data = val;
    @(negedge clk);
    cfg_en = 1'b0; cfg_wr = 1'b0;
  endtask

  task automatic send(input logic [7:0] dest, input int plen, input int seed,
                      input bit corrupt, input int len_field);
    logic [7:0] pk[$];
    logic [7:0] x;
    pk.push_back(dest);
    pk.push_back(8'(seed) ^ 8'h5A);
    pk.push_back(len_field < 0 ? 8'(plen) : 8'(len_field));
    for (int i = 0; i < plen; i++) pk.push_back(8'(seed * 7 + i * 13));
    x = 8'h00;
    foreach (pk[i]) x = x ^ pk[i];
    pk.push_back(corrupt ? ~x : x);
    foreach (pk[i]) begin
      in_valid = 1'b1; in_data = pk[i];
      @(negedge clk);
    end
    in_valid = 1'b0; in_data = 8'h00;
    repeat (3) @(negedge clk);
  endtask

  task automatic drain(input int p, output int cnt);
    cnt = 0;
    while (rdy[p]) begin
      rd[p] = 1'b1; cnt++;
      @(negedge clk);
    end
    rd[p] = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_for(input int p, input int cycles);
    rd[p] = 1'b1;
    repeat (cycles) @(negedge clk);
    rd[p] = 1'b0;
  endtask

  task automatic idle_ready_check(input logic [N-1:0] exp);
    check(rdy === exp, "ready vector", int'(rdy), int'(exp));
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired in phase %s actual=0 expected=1", phase);
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: state right after reset
    phase = "R1";
    check(rdy === '0, "ready under reset", int'(rdy), 0);
    check(odata === '0, "data under reset", int'(odata), 0);
    rst = 1'b0;
    @(negedge clk);
    idle_ready_check('0);

    // R12/R1: all entries are zero after reset, so 0x00 goes to port 0
    phase = "R12";
    send(8'h00, 2, 3, 0, -1);
    idle_ready_check(4'b0001);
    drain(0, n);
    check(n == 6, "bytes on port 0 for tie", n, 6);

    // R2: program table; a read-type access must not change it
    phase = "R2";
    cfg_write(0, 8'h1A, 1); cfg_write(1, 8'h2B, 1);
    cfg_write(2, 8'h3C, 1); cfg_write(3, 8'h4D, 1);
    cfg_write(0, 8'h2B, 0);
    send(8'h1A, 4, 11, 0, -1);
    idle_ready_check(4'b0001);
    drain(0, n);
    check(n == 8, "port 0 byte count", n, 8);

    // R4/R5: one packet per port, various sizes
    phase = "R4";
    send(8'h2B, 0, 21, 0, -1);
    send(8'h3C, 1, 22, 0, -1);
    send(8'h4D, 17, 23, 0, -1);
    idle_ready_check(4'b1110);
    for (int p = 1; p < N; p++) drain(p, n);
    idle_ready_check('0);

    // R3: back-to-back packets with the minimum three-cycle gap, same port
    phase = "R3";
    send(8'h3C, 5, 31, 0, -1);
    send(8'h3C, 9, 32, 0, -1);
    drain(2, n);
    check(n == 22, "two packets merged count", n, 22);

    // R10: bad check byte and wrong length byte still forwarded by strobe
    phase = "R10";
    send(8'h4D, 3, 41, 1, 200);
    drain(3, n);
    check(n == 7, "strobe-framed length", n, 7);

    // R6: read on an empty port
    phase = "R6";
    read_for(1, 6);
    @(negedge clk);
    idle_ready_check('0);

    // R8: unmatched destination dropped
    phase = "R8";
    send(8'h99, 6, 51, 0, -1);
    @(negedge clk);
    idle_ready_check('0);

    // R9: second max packet exceeds free room and is dropped
    phase = "R9";
    send(8'h2B, 255, 61, 0, -1);
    send(8'h2B, 255, 62, 0, -1);
    drain(1, n);
    check(n == 259, "room drop count", n, 259);
    send(8'h2B, 255, 63, 0, -1);
    drain(1, n);
    check(n == 259, "accepted after drain", n, 259);

    // R7: read while the next packet for the same port is arriving
    phase = "R7";
    send(8'h1A, 2, 71, 0, -1);
    fork
      send(8'h1A, 30, 72, 0, -1);
      read_for(0, 12);
    join
    drain(0, n);
    check(n == 34, "remaining after overlap", n, 34);

    // R11: table rewrite during a packet keeps the packet's port
    phase = "R11";
    fork
      send(8'h3C, 20, 81, 0, -1);
      begin repeat (5) @(negedge clk); cfg_write(2, 8'h77, 1); end
    join
    drain(2, n);
    check(n == 24, "in-flight packet kept", n, 24);
    send(8'h3C, 4, 82, 0, -1);
    idle_ready_check('0);
    send(8'h77, 4, 83, 0, -1);
    idle_ready_check(4'b0100);
    drain(2, n);

    // R1: asynchronous reset while data is stored
    phase = "R1";
    send(8'h4D, 8, 91, 0, -1);
    #2 rst = 1'b1;
    #1 check(rdy === '0, "ready after async reset", int'(rdy), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    send(8'h4D, 3, 92, 0, -1);
    idle_ready_check('0);
    send(8'h00, 1, 93, 0, -1);
    idle_ready_check(4'b0001);
    drain(0, n);

    finish_run();
  end
endmodule